// File: doc/BRIEF.md
# SPI Command Engine Host Interface

This block is the processor-facing front end of a command-driven SPI sequencer. Software writes 16-bit instructions and outgoing data bytes through a simple single-cycle register port. These land in two queues that the sequencer drains. Bytes the sequencer collects from the bus land in a third queue that software pops or peeks. Occupancy and free-space readback for each queue lets a driver size its bursts without polling individual full flags.

Four interrupt causes share one level output. The command queue and the transmit queue each have an almost-empty cause, the receive queue has an almost-full cause, and the fourth cause is the sequencer reporting a completed sync instruction together with its 8-bit tag. A software-controlled hold bit flushes every queue and keeps the sequencer in reset until it is released.

Top module: `spi_cmd_host_if`

## Requirements
- R1: A read of offset 0x00 returns the version word: bits 31:24 are zero, bits 23:16 hold the major number (1 by default), bits 15:8 hold the minor number and bits 7:0 hold the patch number (defaults 0 and 0x61, so 0x00010061).
- R2: Writing 1 to bit 0 of offset 0x40 empties all three queues, holds `seqReset` high and ignores pushes. Writing 0 releases the hold. The bit reads back at the same offset and is 0 after reset.
- R3: Offset 0x80 is a read/write enable mask in bits 3:0. `irq` is high while any pending bit is set together with its enable bit. Offset 0x88 reads as pending AND enable.
- R4: Offset 0x84 shows the pending bits. Bit 0 is set in the cycle after the command queue level is at or below CMD_AE_LEVEL (default 2). Bit 1 is set likewise for the transmit queue against TX_AE_LEVEL (default 2). Bit 2 is set in the cycle after the receive queue level is at or above RX_AF_LEVEL (default 6). Each is set again on every cycle its condition holds.
- R5: Writing offset 0x84 clears each pending bit whose write-data bit is 1. A cause that sets a bit in the same cycle as its clear wins, so the bit stays set.
- R6: A one-cycle `syncStrobe` stores `syncId` into the register at offset 0xC0 and sets pending bit 3.
- R7: A write to offset 0xE0 pushes write-data bits 15:0 into the command queue (depth CMD_DEPTH, default 8). The sequencer sees entries in push order on `cmdValid`/`cmdData` and removes one per cycle of `cmdTake`. Offset 0xD0 reads CMD_DEPTH minus the level.
- R8: A write to offset 0xE4 pushes write-data bits 7:0 into the transmit queue (default depth 8). The queue is delivered in order on `txValid`/`txData` and popped by `txTake`. Offset 0xD4 reads the free entries.
- R9: `rxPush` stores `rxData` in the receive queue. Offset 0xD8 reads its level. A read of 0xE8 returns the oldest byte and removes it. A read of 0xEC returns the oldest byte and leaves the level unchanged.
- R10: A push into a full queue is dropped and the level is unchanged. A pop of the empty receive queue reads zero and leaves the level at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops on the receive pop offset) |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRe |
| cmdValid | output | 1 | Command queue holds an entry |
| cmdData | output | 16 | Oldest command |
| cmdTake | input | 1 | Sequencer consumes the oldest command |
| txValid | output | 1 | Transmit queue holds a byte |
| txData | output | 8 | Oldest transmit byte |
| txTake | input | 1 | Sequencer consumes the oldest transmit byte |
| rxPush | input | 1 | Sequencer delivers a received byte |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Receive queue has room |
| syncStrobe | input | 1 | Sequencer finished a sync instruction |
| syncId | input | 8 | Tag of that sync instruction |
| seqReset | output | 1 | Holds the sequencer in reset |
| irq | output | 1 | Level interrupt request |

## Verification
The sync event and a software clear of the sync pending bit can fall in the same clock. The bench provokes this by driving `syncStrobe` with a fresh tag in the very cycle it writes 1 to bit 3 of the pending register. It judges the result by reading back a still-set bit 3 and the new tag. The same set-over-clear rule is also checked on the level causes: a clear of the command almost-empty bit while the queue is full sticks, and the bit returns once the sequencer drains the queue below the threshold.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] ADDR_VERSION  = 8'h00;
  localparam logic [7:0] ADDR_HOLD     = 8'h40;
  localparam logic [7:0] ADDR_ENABLE   = 8'h80;
  localparam logic [7:0] ADDR_PENDING  = 8'h84;
  localparam logic [7:0] ADDR_SOURCE   = 8'h88;
  localparam logic [7:0] ADDR_SYNC_TAG = 8'hC0;
  localparam logic [7:0] ADDR_CMD_ROOM = 8'hD0;
  localparam logic [7:0] ADDR_TX_ROOM  = 8'hD4;
  localparam logic [7:0] ADDR_RX_LEVEL = 8'hD8;
  localparam logic [7:0] ADDR_CMD_PUSH = 8'hE0;
  localparam logic [7:0] ADDR_TX_PUSH  = 8'hE4;
  localparam logic [7:0] ADDR_RX_POP   = 8'hE8;
  localparam logic [7:0] ADDR_RX_PEEK  = 8'hEC;

  localparam int IRQ_CMD_LOW = 0;
  localparam int IRQ_TX_LOW  = 1;
  localparam int IRQ_RX_HIGH = 2;
  localparam int IRQ_SYNC    = 3;
  localparam int IRQ_COUNT   = 4;

  typedef struct packed {
    logic cmdPush;
    logic txPush;
    logic rxPop;
    logic flush;
  } hostStrobe_t;
endpackage

// File: rtl/host_fifo.sv
module host_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  assign headData = empty ? '0 : mem[rdPtr];

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> (count == $past(count)));
  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/spi_host_data.sv
module spi_host_data
  import spi_host_pkg::*;
#(
  parameter int CMD_DEPTH = 8,
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 8,
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1),
  localparam int TX_CW  = $clog2(TX_DEPTH + 1),
  localparam int RX_CW  = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  logic [31:0]       busWdata,
  output logic              cmdValid,
  output logic [15:0]       cmdData,
  input  logic              cmdTake,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txTake,
  input  logic              rxPush,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  input  logic              syncStrobe,
  input  logic [7:0]        syncId,
  output logic [CMD_CW-1:0] cmdLevel,
  output logic [TX_CW-1:0]  txLevel,
  output logic [RX_CW-1:0]  rxLevel,
  output logic [7:0]        rxHead,
  output logic [7:0]        syncTag
);
  logic cmdFull, cmdEmpty, txFull, txEmpty, rxFull, rxEmpty;

  host_fifo #(.WIDTH(16), .DEPTH(CMD_DEPTH)) u_cmdFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(strobe.cmdPush), .pushData(busWdata[15:0]),
    .pop(cmdTake), .headData(cmdData), .count(cmdLevel),
    .full(cmdFull), .empty(cmdEmpty));

  host_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(strobe.txPush), .pushData(busWdata[7:0]),
    .pop(txTake), .headData(txData), .count(txLevel),
    .full(txFull), .empty(txEmpty));

  host_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(rxPush), .pushData(rxData),
    .pop(strobe.rxPop), .headData(rxHead), .count(rxLevel),
    .full(rxFull), .empty(rxEmpty));

  assign cmdValid = !cmdEmpty;
  assign txValid  = !txEmpty;
  assign rxReady  = !rxFull && !strobe.flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           syncTag <= '0;
    else if (syncStrobe) syncTag <= syncId;
  end

  a_r6_tag_capture: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> (syncTag == $past(syncId)));
  a_r9_peek_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rxPop && !rxPush && !strobe.flush) |=> (rxLevel == $past(rxLevel)));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int CMD_DEPTH    = 8,
  parameter int TX_DEPTH     = 8,
  parameter int RX_DEPTH     = 8,
  parameter int CMD_AE_LEVEL = 2,
  parameter int TX_AE_LEVEL  = 2,
  parameter int RX_AF_LEVEL  = 6,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd0,
  parameter logic [7:0] VER_PATCH = 8'h61,
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1),
  localparam int TX_CW  = $clog2(TX_DEPTH + 1),
  localparam int RX_CW  = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output hostStrobe_t       strobe,
  input  logic [CMD_CW-1:0] cmdLevel,
  input  logic [TX_CW-1:0]  txLevel,
  input  logic [RX_CW-1:0]  rxLevel,
  input  logic [7:0]        rxHead,
  input  logic [7:0]        syncTag,
  input  logic              syncStrobe,
  output logic              seqReset,
  output logic              irq
);
  logic holdReg;
  logic [IRQ_COUNT-1:0] enableReg, pendingReg, setMask, clearMask, sourceBits;

  always_comb begin
    strobe.flush   = holdReg;
    strobe.cmdPush = busWe && (busAddr == ADDR_CMD_PUSH) && !holdReg;
    strobe.txPush  = busWe && (busAddr == ADDR_TX_PUSH) && !holdReg;
    strobe.rxPop   = busRe && (busAddr == ADDR_RX_POP) && !holdReg;
  end

  always_comb begin
    setMask = '0;
    setMask[IRQ_CMD_LOW] = (cmdLevel <= CMD_CW'(CMD_AE_LEVEL));
    setMask[IRQ_TX_LOW]  = (txLevel <= TX_CW'(TX_AE_LEVEL));
    setMask[IRQ_RX_HIGH] = (rxLevel >= RX_CW'(RX_AF_LEVEL));
    setMask[IRQ_SYNC]    = syncStrobe;
    clearMask = (busWe && busAddr == ADDR_PENDING) ? busWdata[IRQ_COUNT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg    <= 1'b0;
      enableReg  <= '0;
      pendingReg <= '0;
    end else begin
      if (busWe && busAddr == ADDR_HOLD)   holdReg   <= busWdata[0];
      if (busWe && busAddr == ADDR_ENABLE) enableReg <= busWdata[IRQ_COUNT-1:0];
      pendingReg <= (pendingReg & ~clearMask) | setMask;
    end
  end

  assign sourceBits = pendingReg & enableReg;
  assign irq        = |sourceBits;
  assign seqReset   = holdReg;

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      unique case (busAddr)
        ADDR_VERSION:  busRdata = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
        ADDR_HOLD:     busRdata = {31'd0, holdReg};
        ADDR_ENABLE:   busRdata = 32'(enableReg);
        ADDR_PENDING:  busRdata = 32'(pendingReg);
        ADDR_SOURCE:   busRdata = 32'(sourceBits);
        ADDR_SYNC_TAG: busRdata = 32'(syncTag);
        ADDR_CMD_ROOM: busRdata = 32'(CMD_DEPTH) - 32'(cmdLevel);
        ADDR_TX_ROOM:  busRdata = 32'(TX_DEPTH) - 32'(txLevel);
        ADDR_RX_LEVEL: busRdata = 32'(rxLevel);
        ADDR_RX_POP,
        ADDR_RX_PEEK:  busRdata = 32'(rxHead);
        default:       busRdata = '0;
      endcase
    end
  end

  a_r6_sync_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> pendingReg[IRQ_SYNC]);
  a_r5_clear_sync: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_PENDING && busWdata[IRQ_SYNC] && !syncStrobe)
      |=> !pendingReg[IRQ_SYNC]);
  a_r4_cmd_low_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLevel <= CMD_CW'(CMD_AE_LEVEL)) |=> pendingReg[IRQ_CMD_LOW]);
  a_r4_rx_high_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel >= RX_CW'(RX_AF_LEVEL)) |=> pendingReg[IRQ_RX_HIGH]);
  a_r2_hold_blocks_push: assert property (@(posedge clk) disable iff (!rstN)
    holdReg |-> !(strobe.cmdPush || strobe.txPush));
endmodule

// File: rtl/spi_cmd_host_if.sv
module spi_cmd_host_if
  import spi_host_pkg::*;
#(
  parameter int CMD_DEPTH    = 8,
  parameter int TX_DEPTH     = 8,
  parameter int RX_DEPTH     = 8,
  parameter int CMD_AE_LEVEL = 2,
  parameter int TX_AE_LEVEL  = 2,
  parameter int RX_AF_LEVEL  = 6,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd0,
  parameter logic [7:0] VER_PATCH = 8'h61
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        cmdValid,
  output logic [15:0] cmdData,
  input  logic        cmdTake,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        txTake,
  input  logic        rxPush,
  input  logic [7:0]  rxData,
  output logic        rxReady,
  input  logic        syncStrobe,
  input  logic [7:0]  syncId,
  output logic        seqReset,
  output logic        irq
);
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int TX_CW  = $clog2(TX_DEPTH + 1);
  localparam int RX_CW  = $clog2(RX_DEPTH + 1);

  hostStrobe_t strobe;
  logic [CMD_CW-1:0] cmdLevel;
  logic [TX_CW-1:0]  txLevel;
  logic [RX_CW-1:0]  rxLevel;
  logic [7:0] rxHead, syncTag;

  spi_host_ctrl #(
    .CMD_DEPTH(CMD_DEPTH), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
    .CMD_AE_LEVEL(CMD_AE_LEVEL), .TX_AE_LEVEL(TX_AE_LEVEL), .RX_AF_LEVEL(RX_AF_LEVEL),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe),
    .cmdLevel(cmdLevel), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxHead(rxHead), .syncTag(syncTag), .syncStrobe(syncStrobe),
    .seqReset(seqReset), .irq(irq));

  spi_host_data #(
    .CMD_DEPTH(CMD_DEPTH), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .cmdValid(cmdValid), .cmdData(cmdData), .cmdTake(cmdTake),
    .txValid(txValid), .txData(txData), .txTake(txTake),
    .rxPush(rxPush), .rxData(rxData), .rxReady(rxReady),
    .syncStrobe(syncStrobe), .syncId(syncId),
    .cmdLevel(cmdLevel), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxHead(rxHead), .syncTag(syncTag));
endmodule

// File: tb/spi_cmd_host_if_bench.sv
module spi_cmd_host_if_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWe = 0, busRe = 0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic cmdValid, txValid, rxReady, seqReset, irq;
  logic [15:0] cmdData;
  logic [7:0] txData;
  logic cmdTake = 0, txTake = 0, rxPush = 0, syncStrobe = 0;
  logic [7:0] rxData = '0, syncId = '0;
  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_host_if u_spi_cmd_host_if (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cmdValid(cmdValid),
    .cmdData(cmdData), .cmdTake(cmdTake), .txValid(txValid), .txData(txData),
    .txTake(txTake), .rxPush(rxPush), .rxData(rxData), .rxReady(rxReady),
    .syncStrobe(syncStrobe), .syncId(syncId), .seqReset(seqReset), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busRe = 1; busAddr = a; #1 d = busRdata;
    @(negedge clk); busRe = 0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic stubPushRx(input logic [7:0] b);
    @(negedge clk); rxPush = 1; rxData = b;
    @(negedge clk); rxPush = 0;
  endtask

  task automatic stubTakeCmd(input logic [15:0] exp);
    @(negedge clk);
    check("R7 cmdValid", 32'(cmdValid), 32'd1);
    check("R7 cmd order", 32'(cmdData), 32'(exp));
    cmdTake = 1;
    @(negedge clk); cmdTake = 0;
  endtask

  task automatic stubTakeTx(input logic [7:0] exp);
    @(negedge clk);
    check("R8 tx order", 32'(txData), 32'(exp));
    txTake = 1;
    @(negedge clk); txTake = 0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    readCheck("R4 reset pending", 8'h84, 32'h3);
    readCheck("R3 reset enable", 8'h80, 32'h0);
    check("R3 reset irq", 32'(irq), 32'd0);
    check("R2 reset seqReset", 32'(seqReset), 32'd0);
    readCheck("R7 reset cmd room", 8'hD0, 32'd8);
    readCheck("R9 reset rx level", 8'hD8, 32'd0);
  endtask

  task automatic testVersion();
    readCheck("R1 version", 8'h00, 32'h0001_0061);
  endtask

  task automatic testCmdQueue();
    for (int i = 0; i < 9; i++) busWrite(8'hE0, 32'hABCD_1000 + 32'(i));
    readCheck("R10 cmd room when full", 8'hD0, 32'd0);
    busWrite(8'h84, 32'h1);
    readCheck("R5 clear cmd-low while full", 8'h84, 32'h2);
    for (int i = 0; i < 8; i++) stubTakeCmd(16'h1000 + 16'(i));
    @(negedge clk);
    check("R10 ninth command dropped", 32'(cmdValid), 32'd0);
    readCheck("R4 cmd-low set again", 8'h84, 32'h3);
  endtask

  task automatic testTxQueue();
    busWrite(8'hE4, 32'h111);
    busWrite(8'hE4, 32'h22);
    busWrite(8'hE4, 32'h33);
    readCheck("R8 tx room", 8'hD4, 32'd5);
    stubTakeTx(8'h11); stubTakeTx(8'h22); stubTakeTx(8'h33);
    @(negedge clk);
    check("R8 tx drained", 32'(txValid), 32'd0);
  endtask

  task automatic testRxAndIrq();
    for (int i = 0; i < 6; i++) stubPushRx(8'hA0 + 8'(i));
    readCheck("R9 rx level", 8'hD8, 32'd6);
    readCheck("R4 rx-high pending", 8'h84, 32'h7);
    busWrite(8'h80, 32'h4);
    check("R3 irq on", 32'(irq), 32'd1);
    readCheck("R3 source masked", 8'h88, 32'h4);
    readCheck("R9 peek", 8'hEC, 32'hA0);
    readCheck("R9 peek again", 8'hEC, 32'hA0);
    readCheck("R9 level after peek", 8'hD8, 32'd6);
    for (int i = 0; i < 6; i++) readCheck("R9 pop order", 8'hE8, 32'hA0 + 32'(i));
    readCheck("R10 empty pop reads zero", 8'hE8, 32'h0);
    readCheck("R10 level stays zero", 8'hD8, 32'd0);
    busWrite(8'h84, 32'h4);
    check("R3 irq off after clear", 32'(irq), 32'd0);
    busWrite(8'h80, 32'h0);
  endtask

  task automatic testSync();
    @(negedge clk); syncStrobe = 1; syncId = 8'h5A;
    @(negedge clk); syncStrobe = 0;
    readCheck("R6 tag stored", 8'hC0, 32'h5A);
    readCheck("R6 pending bit3", 8'h84, 32'hB);
    busWrite(8'h84, 32'h8);
    readCheck("R5 sync cleared", 8'h84, 32'h3);
    @(negedge clk);
    busWe = 1; busAddr = 8'h84; busWdata = 32'h8;
    syncStrobe = 1; syncId = 8'h77;
    @(negedge clk); busWe = 0; syncStrobe = 0;
    readCheck("R5 set wins over clear", 8'h84, 32'hB);
    readCheck("R6 new tag", 8'hC0, 32'h77);
  endtask

  task automatic testHold();
    busWrite(8'hE0, 32'h1);
    busWrite(8'hE0, 32'h2);
    stubPushRx(8'h5);
    busWrite(8'h40, 32'h1);
    check("R2 seqReset held", 32'(seqReset), 32'd1);
    readCheck("R2 cmd flushed", 8'hD0, 32'd8);
    readCheck("R2 rx flushed", 8'hD8, 32'd0);
    busWrite(8'hE0, 32'h9);
    readCheck("R2 push ignored in hold", 8'hD0, 32'd8);
    readCheck("R2 hold readback", 8'h40, 32'h1);
    busWrite(8'h40, 32'h0);
    check("R2 seqReset released", 32'(seqReset), 32'd0);
    busWrite(8'hE0, 32'h4);
    readCheck("R2 push after release", 8'hD0, 32'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testVersion();
    testCmdQueue();
    testTxQueue();
    testRxAndIrq();
    testSync();
    testHold();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule